// File: doc/BRIEF.md
# Bus target data-in sender

This block is the target side of a parallel peripheral bus during a data-in transfer. Software or an upstream engine programs a byte count and pulses `start`. The block then pulls bytes from a valid/ready stream, one at a time. It places each byte on the data lines together with an odd-parity bit and runs a four-edge REQ/ACK handshake with the initiator for every byte.

Before it raises REQ, the block always waits until ACK has been released. After the last byte it waits for that release once more before it reports completion. One pause can be programmed: when the transfer reaches a chosen byte index, the stream is held off for a set number of cycles before that byte is taken.

Every wait on ACK is bounded by a cycle limit. The bus reset line ends the transfer at once from any active state. A single-cycle `done` pulse returns the number of bytes the initiator acknowledged and a status code.

Top module: `scsi_datain_tx`

## Requirements
- R1: Every byte is driven on `bus_data` with a `bus_parity` value such that the nine lines together carry an odd number of ones.
- R2: `bus_req` rises only in the cycle after ACK was sampled low with the byte already on the bus. While ACK is held high, REQ never rises. `bus_data` and `bus_parity` stay stable while `bus_req` is high.
- R3: Once ACK is sampled high while REQ is high, `bus_req` is low in the next cycle and that byte counts as sent.
- R4: After the last byte, `done` with status complete appears only after ACK has been sampled low. If ACK is held high, completion is delayed until it is released.
- R5: `s_ready` is high only while the block is waiting for a byte to place. Bytes reach the bus in stream order, exactly `xfer_len` of them.
- R6: With `pause_en` set and `pause_idx` < `xfer_len`, the block stalls before taking byte number `pause_idx` (counting from 0). During the stall `s_ready` and `bus_req` are held low for `pause_cycles`+2 cycles. The stall happens once. With the pause disabled, or `pause_idx` ≥ `xfer_len`, there is no stall.
- R7: An ACK wait that lasts `ACK_TO` cycles ends the transfer with status 2'd1 (timeout). The count is the number of bytes completed, which is `xfer_len` when the timeout occurs in the final wait.
- R8: `bus_rst` high in any active cycle ends the transfer. In the next cycle `done` is high with status 2'd2 (bus reset), `bus_req` is low and the count is the number of bytes completed.
- R9: `done` is a one-cycle pulse. A normal finish gives status 2'd0 (complete) and count `xfer_len`. A zero-length transfer finishes once ACK is low, with count 0.
- R10: `bus_req` is low whenever the block is idle. A `start` pulse while busy is ignored.
- R11: After reset, `bus_req`, `s_ready`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| xfer_len | input | CNT_W | Number of bytes to send |
| pause_en | input | 1 | Enable the one-time pause |
| pause_idx | input | CNT_W | Byte index before which the pause occurs |
| pause_cycles | input | PAUSE_W | Pause length parameter |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block takes the stream byte this cycle |
| bus_ack | input | 1 | Initiator ACK, active high |
| bus_rst | input | 1 | Bus reset, active high |
| bus_req | output | 1 | Target REQ, active high |
| bus_data | output | 8 | Data lines |
| bus_parity | output | 1 | Odd parity over the data lines |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Bytes acknowledged by the initiator |
| done_status | output | 2 | 0 complete, 1 timeout, 2 bus reset |

## Verification
A wrong state shows up at the ports within one handshake. A REQ raised while ACK is still high, or a REQ held after ACK arrives, is visible on the very next edge. A lost or repeated byte shows as a data mismatch at the initiator's capture. A skipped final ACK-release wait shows as a `done` that precedes ACK's fall. A stall placed at the wrong index, or applied twice, shows as a long `s_ready` gap at the wrong byte count. Miscounting timers or abort paths show in `done_count` and `done_status` on the single `done` pulse.

// File: rtl/scsi_datain_tx.sv
module scsi_datain_tx #(
  parameter int CNT_W   = 16,
  parameter int PAUSE_W = 16,
  parameter int ACK_TO  = 375_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   xfer_len,
  input  logic               pause_en,
  input  logic [CNT_W-1:0]   pause_idx,
  input  logic [PAUSE_W-1:0] pause_cycles,
  input  logic               s_valid,
  input  logic [7:0]         s_data,
  output logic               s_ready,
  input  logic               bus_ack,
  input  logic               bus_rst,
  output logic               bus_req,
  output logic [7:0]         bus_data,
  output logic               bus_parity,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   done_count,
  output logic [1:0]         done_status
);
  localparam int TO_W = $clog2(ACK_TO + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_TO = 2'd1, ST_RST = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_PAUSE, S_WREL, S_WASS, S_FINAL} state_t;
  state_t state;

  logic [CNT_W-1:0]   len_q, pidx_q, sent;
  logic [PAUSE_W-1:0] pcnt;
  logic [TO_W-1:0]    tmr;
  logic               pen_q;

  wire [CNT_W-1:0] sent_nx   = sent + 1'b1;
  wire             pause_hit = pen_q && (sent == pidx_q);
  wire             expired   = (tmr == TO_W'(ACK_TO - 1));

  assign busy    = (state != S_IDLE);
  assign s_ready = (state == S_FETCH) && !pause_hit && !bus_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      len_q       <= '0;
      pidx_q      <= '0;
      pen_q       <= 1'b0;
      pcnt        <= '0;
      sent        <= '0;
      tmr         <= '0;
      bus_req     <= 1'b0;
      bus_data    <= '0;
      bus_parity  <= 1'b1;
      done        <= 1'b0;
      done_count  <= '0;
      done_status <= ST_OK;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          len_q  <= xfer_len;
          pidx_q <= pause_idx;
          pen_q  <= pause_en;
          pcnt   <= pause_cycles;
          sent   <= '0;
          tmr    <= '0;
          state  <= (xfer_len == '0) ? S_FINAL : S_FETCH;
        end
      end else if (bus_rst) begin
        bus_req     <= 1'b0;
        done        <= 1'b1;
        done_count  <= sent;
        done_status <= ST_RST;
        state       <= S_IDLE;
      end else begin
        case (state)
          S_FETCH: begin
            if (pause_hit) begin
              pen_q <= 1'b0;
              state <= S_PAUSE;
            end else if (s_valid) begin
              bus_data   <= s_data;
              bus_parity <= ~^s_data;
              tmr        <= '0;
              state      <= S_WREL;
            end
          end
          S_PAUSE: begin
            if (pcnt == '0) state <= S_FETCH;
            else            pcnt  <= pcnt - 1'b1;
          end
          S_WREL: begin
            if (!bus_ack) begin
              bus_req <= 1'b1;
              tmr     <= '0;
              state   <= S_WASS;
            end else if (expired) begin
              done        <= 1'b1;
              done_count  <= sent;
              done_status <= ST_TO;
              state       <= S_IDLE;
            end else tmr <= tmr + 1'b1;
          end
          S_WASS: begin
            if (bus_ack) begin
              bus_req <= 1'b0;
              sent    <= sent_nx;
              tmr     <= '0;
              state   <= (sent_nx == len_q) ? S_FINAL : S_FETCH;
            end else if (expired) begin
              bus_req     <= 1'b0;
              done        <= 1'b1;
              done_count  <= sent;
              done_status <= ST_TO;
              state       <= S_IDLE;
            end else tmr <= tmr + 1'b1;
          end
          S_FINAL: begin
            if (!bus_ack) begin
              done        <= 1'b1;
              done_count  <= sent;
              done_status <= ST_OK;
              state       <= S_IDLE;
            end else if (expired) begin
              done        <= 1'b1;
              done_count  <= sent;
              done_status <= ST_TO;
              state       <= S_IDLE;
            end else tmr <= tmr + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_datain_tx_chk.sv
module scsi_datain_tx_chk #(
  parameter int CNT_W   = 16,
  parameter int PAUSE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CNT_W-1:0]   xfer_len,
  input logic               pause_en,
  input logic [CNT_W-1:0]   pause_idx,
  input logic [PAUSE_W-1:0] pause_cycles,
  input logic               s_valid,
  input logic [7:0]         s_data,
  input logic               s_ready,
  input logic               bus_ack,
  input logic               bus_rst,
  input logic               bus_req,
  input logic [7:0]         bus_data,
  input logic               bus_parity,
  input logic               busy,
  input logic               done,
  input logic [CNT_W-1:0]   done_count,
  input logic [1:0]         done_status
);
  p_parity_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones({bus_data, bus_parity}) % 2 == 1));

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(bus_ack));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> ($stable(bus_data) && $stable(bus_parity)));

  p_req_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_rst) |=> !bus_req);

  p_final_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 2'd0) |-> !$past(bus_ack));

  p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !bus_req));

  p_rst_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rst) |=> (done && done_status == 2'd2 && !bus_req && !busy));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

bind scsi_datain_tx scsi_datain_tx_chk #(.CNT_W(CNT_W), .PAUSE_W(PAUSE_W)) u_chk (.*);

// File: tb/scsi_datain_tx_bench.sv
`timescale 1ns/1ps
module scsi_datain_tx_bench;
  localparam int CNT_W = 16, PAUSE_W = 8, ACK_TO = 64, PCYC = 40;

  logic clk = 0, rst_n = 0, start = 0, pause_en = 0, s_valid = 0, bus_ack = 0, bus_rst = 0;
  logic [CNT_W-1:0] xfer_len = 0, pause_idx = 0;
  logic [PAUSE_W-1:0] pause_cycles = PCYC;
  logic [7:0] s_data = 0;
  logic s_ready, bus_req, bus_parity, busy, done;
  logic [7:0] bus_data;
  logic [CNT_W-1:0] done_count;
  logic [1:0] done_status;

  scsi_datain_tx #(.CNT_W(CNT_W), .PAUSE_W(PAUSE_W), .ACK_TO(ACK_TO)) u_scsi_datain_tx (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] arr [16];
  bit iclr = 0;
  int flen = 0, exp_len = 0;
  int stop_after = -1, rst_at = -1, hold_final = 0;
  bit pre_ack = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // stream feeder
  int fidx = 0; bit pend = 0;
  always @(negedge clk) begin
    if (iclr) begin
      fidx = 0; pend = 0; s_valid = 0;
    end else begin
      if (pend) begin fidx++; s_valid = 0; end
      if (!s_valid && fidx < flen && ($urandom % 4) != 0) begin
        s_valid = 1; s_data = arr[fidx];
      end
      pend = s_valid && s_ready;
    end
  end

  // initiator model
  int ist = 0, rx_cnt = 0, dly = 0, ack_fall_cyc = 0;
  bit req_seen = 0, first2 = 0;
  always @(negedge clk) begin
    if (iclr) begin
      ist = 0; rx_cnt = 0; bus_ack = 0; bus_rst = 0; req_seen = 0;
    end else begin
      if (bus_req) req_seen = 1;
      case (ist)
        0: begin
          if (pre_ack) bus_ack = 1;
          else if (bus_req) begin
            if (rst_at == rx_cnt) begin bus_rst = 1; dly = 1; ist = 4; end
            else if (stop_after != rx_cnt) begin
              chk(bus_data == arr[rx_cnt], "R5 byte order", bus_data, arr[rx_cnt]);
              chk(^{bus_data, bus_parity} == 1'b1, "R1 odd parity", bus_parity, ~^bus_data);
              dly = $urandom % 4; ist = 1;
            end
          end
        end
        1: if (dly == 0) begin bus_ack = 1; ist = 2; first2 = 1; end else dly--;
        2: begin
          if (first2) chk(!bus_req, "R3 req fall after ack", bus_req, 0);
          first2 = 0;
          if (!bus_req) begin
            rx_cnt++;
            dly = (rx_cnt == exp_len) ? hold_final : $urandom % 4;
            ist = 3;
          end
        end
        3: if (dly == 0) begin bus_ack = 0; ack_fall_cyc = cyc; ist = 0; end else dly--;
        4: if (dly == 0) begin bus_rst = 0; ist = 5; end else dly--;
        default: ;
      endcase
    end
  end

  // done and stall monitor
  int dn_seen = 0, dn_cnt = 0, dn_st = 0, dn_cyc = 0, run = 0, pause_hits = 0, pause_at = -1;
  always @(negedge clk) begin
    if (iclr) begin
      dn_seen = 0; run = 0; pause_hits = 0; pause_at = -1;
    end else begin
      if (done) begin dn_seen++; dn_cnt = done_count; dn_st = done_status; dn_cyc = cyc; end
      if (busy && !s_ready && !bus_req && !bus_ack) begin
        run++;
        if (run == PCYC - 4) begin pause_hits++; pause_at = rx_cnt; end
      end else run = 0;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic run_case(input int len, input bit pen, input int pidx, input bit restart);
    int n, est, ecnt;
    iclr = 1; tick(); tick(); iclr = 0;
    for (int i = 0; i < 16; i++) arr[i] = 8'($urandom);
    flen = len; exp_len = len;
    xfer_len = CNT_W'(len); pause_en = pen; pause_idx = CNT_W'(pidx); pause_cycles = PCYC;
    start = 1; tick(); start = 0;
    if (restart) begin
      repeat (5) tick();
      xfer_len = CNT_W'(len + 3); start = 1; tick(); start = 0;
    end
    n = 0;
    while (dn_seen == 0 && n < 4000) begin tick(); n++; end
    est = 0; ecnt = len;
    if (pre_ack) begin est = 1; ecnt = 0; end
    else if (rst_at >= 0 && rst_at < len) begin est = 2; ecnt = rst_at; end
    else if (stop_after >= 0 && stop_after < len) begin est = 1; ecnt = stop_after; end
    else if (hold_final >= ACK_TO) est = 1;
    chk(dn_seen == 1, "R9 done seen", dn_seen, 1);
    chk(dn_st == est, est == 2 ? "R8 status" : est == 1 ? "R7 status" : "R9 status", dn_st, est);
    chk(dn_cnt == ecnt, est == 2 ? "R8 count" : est == 1 ? "R7 count" : "R9 count", dn_cnt, ecnt);
    repeat (6) tick();
    chk(dn_seen == 1, "R9 single done pulse", dn_seen, 1);
    chk(!bus_req && !busy, "R10 idle req low", bus_req, 0);
    if (est == 0 && hold_final > 0)
      chk(dn_cyc > ack_fall_cyc, "R4 done after final release", dn_cyc, ack_fall_cyc + 1);
    if (est == 0) begin
      if (pen && pidx < len) begin
        chk(pause_hits == 1, "R6 pause once", pause_hits, 1);
        chk(pause_at == pidx, "R6 pause index", pause_at, pidx);
      end else chk(pause_hits == 0, "R6 no pause", pause_hits, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    chk(!bus_req && !s_ready && !busy && !done, "R11 reset state", {bus_req, s_ready, busy, done}, 0);
    rst_n = 1; tick();
    chk(!bus_req && !busy, "R11 after release", {bus_req, busy}, 0);

    run_case(1, 0, 0, 0);
    run_case(5, 0, 0, 0);
    run_case(0, 0, 0, 0);                          // R9 zero length
    run_case(6, 1, 0, 0);                          // R6 pause before first byte
    run_case(6, 1, 6, 0);                          // R6 index at length: no pause
    run_case(6, 0, 0, 1);                          // R10 restart while busy ignored
    for (int k = 0; k < 14; k++) begin
      int l = 1 + ($urandom % 12);
      run_case(l, 1'($urandom % 2), $urandom % (l + 2), 0);
    end
    stop_after = 3; run_case(6, 0, 0, 0); stop_after = -1;     // R7 timeout waiting for ACK
    pre_ack = 1; run_case(4, 0, 0, 0);                         // R2 ACK held high
    chk(!req_seen, "R2 no req while ack high", req_seen, 0);
    pre_ack = 0;
    hold_final = 200; run_case(3, 0, 0, 0);                    // R7 timeout in final wait
    hold_final = 20;  run_case(3, 0, 0, 0); hold_final = 0;    // R4 delayed completion
    rst_at = 2; run_case(5, 0, 0, 0); rst_at = -1;             // R8 bus reset mid transfer
    rst_at = 0; run_case(1, 0, 0, 0); rst_at = -1;             // R8 reset at first byte
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule